// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a bank of already-synchronized GPIO input pins and turns selected pin conditions into one interrupt request. Each pin is set up on its own through three configuration words: a detection kind (level or edge), a sense (high/rising or low/falling), and a both-edges selector that matters only for edge detection. Every detected condition sets a sticky status bit for that pin. Software clears a status bit by writing a 1 to it.

A per-pin mask decides which status bits may reach the interrupt output. The mask is never written directly. One write-only word clears mask bits (unmasks pins) and another sets them (masks pins), and the current mask is read from a separate read-only word. Masking only stops propagation to the output. Detection and status capture go on while a pin is masked, so a condition seen while masked raises the interrupt as soon as the pin is unmasked. Software that wants to avoid this clears the status bit before it unmasks the pin.

The register bus is a simple single-cycle port: a write strobe with address and data, and a read data output that follows the address combinationally.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every mask bit reads 1, and status, kind, sense and both-edges all read 0. The interrupt output is low.
- R2: A pin whose kind bit is 0 is level-detected. Its sense bit 1 means active-high and 0 means active-low. While the level is active, the status bit is set again on every clock, so a clear only holds once the pin has gone inactive. A bit that has been set stays set after the pin goes inactive.
- R3: A pin whose kind bit is 1 is edge-detected against its value at the previous clock. Its sense bit 1 selects rising and 0 selects falling. One transition sets status once, and a pin that holds its value afterwards does not set it again.
- R4: When a pin's both-edges bit is 1 in edge mode, rising and falling transitions both set status and the sense bit is ignored. In level mode the both-edges bit has no effect.
- R5: Writing to offset 0x10 clears each mask bit whose data bit is 1. Writing to offset 0x14 sets each mask bit whose data bit is 1. Data bits of 0 leave the mask unchanged, so writing all ones to 0x14 masks every pin. The mask reads back at offset 0x0C, where 1 means masked. No other write changes the mask.
- R6: Writing to offset 0x18 clears each status bit whose data bit is 1 and leaves the other status bits alone. If a new detection hits the same bit in the same clock, the detection wins and the bit stays 1.
- R7: A condition detected on a masked pin is still latched in status. Unmasking that pin then raises the interrupt output in the clock after the unmask write.
- R8: The interrupt output is 1 exactly when some pin has both its status bit set and its mask bit clear.
- R9: Kind is read and written at offset 0x1C, sense at 0x20 and both-edges at 0x24. The write-only offsets 0x10 and 0x14 read as 0, as does any unmapped offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| pin_i | input | PIN_CNT | Synchronized GPIO pin levels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | PIN_CNT | Register write data, one bit per pin |
| bus_rdata | output | PIN_CNT | Register read data for bus_addr |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Directed sequences come first. A single falling transition on a pin set for falling edges, next to a pin set for rising edges, shows that the sense bit picks the edge. A hold after the transition shows that edges are one-shot. A both-edges pin toggled both ways shows that the sense bit is ignored there. A level pin held active while its status is cleared shows the level re-setting the bit, and an edge that arrives in the same clock as a clear shows that detection takes priority. A pin that is active while masked and then unmasked separates stopping detection from stopping propagation. A long random run then mixes sparse pin toggles with random writes to every offset, including an unmapped one. That run checks the output and every readback against a bench model, which catches mistakes in how configuration, mask updates and clears interact.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Byte offsets of the register words inside the bank window
  localparam logic [7:0] OFS_MASK = 8'h0C;
  localparam logic [7:0] OFS_UNMK = 8'h10;
  localparam logic [7:0] OFS_MSK  = 8'h14;
  localparam logic [7:0] OFS_STS  = 8'h18;
  localparam logic [7:0] OFS_KIND = 8'h1C;
  localparam logic [7:0] OFS_SNS  = 8'h20;
  localparam logic [7:0] OFS_BOTH = 8'h24;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_UNMK,
    SEL_MSK,
    SEL_STS,
    SEL_KIND,
    SEL_SNS,
    SEL_BOTH
  } reg_sel_e;

endpackage

// File: rtl/gpio_irq_rst_sync.sv
module gpio_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_regfile.sv
module gpio_irq_regfile
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PIN_CNT = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [PIN_CNT-1:0] bus_wdata,
  input  logic [PIN_CNT-1:0] status_i,
  output logic [PIN_CNT-1:0] kind_o,
  output logic [PIN_CNT-1:0] sense_o,
  output logic [PIN_CNT-1:0] both_o,
  output logic [PIN_CNT-1:0] mask_o,
  output logic [PIN_CNT-1:0] clr_o,
  output logic [PIN_CNT-1:0] rdata_o
);
  reg_sel_e           sel;
  logic [PIN_CNT-1:0] kind_q, sense_q, both_q, mask_q;
  logic [PIN_CNT-1:0] mask_d;
  logic               kind_ce, sense_ce, both_ce, mask_ce;

  // Address decode
  always_comb begin
    if      (bus_addr == ADDR_W'(OFS_MASK)) sel = SEL_MASK;
    else if (bus_addr == ADDR_W'(OFS_UNMK)) sel = SEL_UNMK;
    else if (bus_addr == ADDR_W'(OFS_MSK))  sel = SEL_MSK;
    else if (bus_addr == ADDR_W'(OFS_STS))  sel = SEL_STS;
    else if (bus_addr == ADDR_W'(OFS_KIND)) sel = SEL_KIND;
    else if (bus_addr == ADDR_W'(OFS_SNS))  sel = SEL_SNS;
    else if (bus_addr == ADDR_W'(OFS_BOTH)) sel = SEL_BOTH;
    else                                    sel = SEL_NONE;
  end

  // Next-state and clock enables
  always_comb begin
    kind_ce  = bus_we && (sel == SEL_KIND);
    sense_ce = bus_we && (sel == SEL_SNS);
    both_ce  = bus_we && (sel == SEL_BOTH);
    mask_ce  = bus_we && ((sel == SEL_UNMK) || (sel == SEL_MSK));
    if (sel == SEL_UNMK) begin
      mask_d = mask_q & ~bus_wdata;
    end else begin
      mask_d = mask_q | bus_wdata;
    end
    clr_o = (bus_we && (sel == SEL_STS)) ? bus_wdata : '0;
  end

  // Read mux
  always_comb begin
    unique case (sel)
      SEL_MASK: rdata_o = mask_q;
      SEL_STS:  rdata_o = status_i;
      SEL_KIND: rdata_o = kind_q;
      SEL_SNS:  rdata_o = sense_q;
      SEL_BOTH: rdata_o = both_q;
      default:  rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= '0;
      sense_q <= '0;
      both_q  <= '0;
      mask_q  <= '1;
    end else begin
      if (kind_ce)  kind_q  <= bus_wdata;
      if (sense_ce) sense_q <= bus_wdata;
      if (both_ce)  both_q  <= bus_wdata;
      if (mask_ce)  mask_q  <= mask_d;
    end
  end

  assign kind_o  = kind_q;
  assign sense_o = sense_q;
  assign both_o  = both_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned PIN_CNT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIN_CNT-1:0] pin_i,
  input  logic [PIN_CNT-1:0] kind_i,
  input  logic [PIN_CNT-1:0] sense_i,
  input  logic [PIN_CNT-1:0] both_i,
  output logic [PIN_CNT-1:0] hit_o
);
  logic [PIN_CNT-1:0] prev_q;
  logic [PIN_CNT-1:0] rise, fall, edge_hit, lvl_hit;

  // Previous sample; kind resets to level, so the reset value is never used as an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= pin_i;
    end
  end

  for (genvar g = 0; g < PIN_CNT; g++) begin : g_pin
    assign rise[g]     = pin_i[g] & ~prev_q[g];
    assign fall[g]     = ~pin_i[g] & prev_q[g];
    assign edge_hit[g] = both_i[g] ? (rise[g] | fall[g])
                                   : (sense_i[g] ? rise[g] : fall[g]);
    assign lvl_hit[g]  = sense_i[g] ? pin_i[g] : ~pin_i[g];
    assign hit_o[g]    = kind_i[g] ? edge_hit[g] : lvl_hit[g];
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned PIN_CNT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIN_CNT-1:0] hit_i,
  input  logic [PIN_CNT-1:0] clr_i,
  input  logic [PIN_CNT-1:0] mask_i,
  output logic [PIN_CNT-1:0] status_o,
  output logic               irq_o
);
  logic [PIN_CNT-1:0] sts_q, sts_d;
  logic               sts_ce;

  always_comb begin
    // new detection takes priority over a clear of the same bit
    sts_d  = (sts_q & ~clr_i) | hit_i;
    sts_ce = |(clr_i | hit_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (sts_ce) begin
      sts_q <= sts_d;
    end
  end

  assign status_o = sts_q;
  assign irq_o    = |(sts_q & ~mask_i);
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned PIN_CNT = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIN_CNT-1:0] pin_i,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [PIN_CNT-1:0] bus_wdata,
  output logic [PIN_CNT-1:0] bus_rdata,
  output logic               irq_o
);
  logic               rst_sync_n;
  logic [PIN_CNT-1:0] kind_w, sense_w, both_w, mask_w, clr_w, hit_w, sts_w;

  gpio_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  gpio_irq_regfile #(.PIN_CNT(PIN_CNT), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status_i  (sts_w),
    .kind_o    (kind_w),
    .sense_o   (sense_w),
    .both_o    (both_w),
    .mask_o    (mask_w),
    .clr_o     (clr_w),
    .rdata_o   (bus_rdata)
  );

  gpio_irq_detect #(.PIN_CNT(PIN_CNT)) u_det (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pin_i   (pin_i),
    .kind_i  (kind_w),
    .sense_i (sense_w),
    .both_i  (both_w),
    .hit_o   (hit_w)
  );

  gpio_irq_status #(.PIN_CNT(PIN_CNT)) u_sts (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hit_i    (hit_w),
    .clr_i    (clr_w),
    .mask_i   (mask_w),
    .status_o (sts_w),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PIN_CNT = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PIN_CNT-1:0] pin_i,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [PIN_CNT-1:0] bus_wdata,
  input logic [PIN_CNT-1:0] kind,
  input logic [PIN_CNT-1:0] sense,
  input logic [PIN_CNT-1:0] both,
  input logic [PIN_CNT-1:0] mask,
  input logic [PIN_CNT-1:0] status,
  input logic               irq
);
  logic [PIN_CNT-1:0] pin_d;
  logic [PIN_CNT-1:0] lvl_v, rise_v;
  logic               wr_unmk, wr_msk, wr_sts;

  always_ff @(posedge clk) pin_d <= pin_i;

  assign wr_unmk = bus_we && (bus_addr == ADDR_W'(OFS_UNMK));
  assign wr_msk  = bus_we && (bus_addr == ADDR_W'(OFS_MSK));
  assign wr_sts  = bus_we && (bus_addr == ADDR_W'(OFS_STS));
  assign lvl_v   = ~kind & ~(pin_i ^ sense);
  assign rise_v  = kind & ~both & sense & pin_i & ~pin_d;

  p_unmask_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmk |=> ((mask & $past(bus_wdata)) == '0));

  p_mask_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_msk |=> ((mask & $past(bus_wdata)) == $past(bus_wdata)));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_unmk || wr_msk) |=> $stable(mask));

  p_status_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sts |=> ((status & $past(status)) == $past(status)));

  p_all_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);

  p_level_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(lvl_v)) == $past(lvl_v)));

  p_rise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(rise_v)) == $past(rise_v)));
endmodule

bind gpio_irq_unit gpio_irq_chk #(.PIN_CNT(PIN_CNT), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .pin_i     (pin_i),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .kind      (kind_w),
  .sense     (sense_w),
  .both      (both_w),
  .mask      (mask_w),
  .status    (sts_w),
  .irq       (irq_o)
);

// File: tb/tb_gpio_irq_unit.sv
`timescale 1ns/1ps
module tb_gpio_irq_unit;
  import gpio_irq_pkg::*;
  localparam int N  = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  pins;
  logic          we;
  logic [AW-1:0] addr;
  logic [N-1:0]  wdata;
  logic [N-1:0]  rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_unit #(.PIN_CNT(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  // Bench model built from the requirements
  logic [N-1:0] m_mask, m_sts, m_kind, m_sns, m_both, m_prev;

  function automatic logic [N-1:0] m_hit(logic [N-1:0] p);
    logic [N-1:0] r, f, e, l;
    r = p & ~m_prev;
    f = ~p & m_prev;
    e = (m_both & (r | f)) | (~m_both & ((m_sns & r) | (~m_sns & f)));
    l = (m_sns & p) | (~m_sns & ~p);
    return (m_kind & e) | (~m_kind & l);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = '1; m_sts = '0; m_kind = '0; m_sns = '0; m_both = '0; m_prev = '0;
    end else begin
      logic [N-1:0] h, c;
      h = m_hit(pins);
      c = (we && addr == OFS_STS) ? wdata : '0;
      m_sts = (m_sts & ~c) | h;
      if (we && addr == OFS_UNMK) m_mask = m_mask & ~wdata;
      if (we && addr == OFS_MSK)  m_mask = m_mask | wdata;
      if (we && addr == OFS_KIND) m_kind = wdata;
      if (we && addr == OFS_SNS)  m_sns  = wdata;
      if (we && addr == OFS_BOTH) m_both = wdata;
      m_prev = pins;
    end
  end

  function automatic logic [N-1:0] m_read(logic [AW-1:0] a);
    case (a)
      OFS_MASK: return m_mask;
      OFS_STS:  return m_sts;
      OFS_KIND: return m_kind;
      OFS_SNS:  return m_sns;
      OFS_BOTH: return m_both;
      default:  return '0;
    endcase
  endfunction

  function automatic string read_tag(logic [AW-1:0] a);
    case (a)
      OFS_MASK: return "R5 mask readback";
      OFS_STS:  return "R6 status readback";
      default:  return "R9 register readback";
    endcase
  endfunction

  function automatic logic [AW-1:0] pick_addr(int idx);
    case (idx)
      0: return OFS_MASK;
      1: return OFS_UNMK;
      2: return OFS_MSK;
      3: return OFS_STS;
      4: return OFS_KIND;
      5: return OFS_SNS;
      6: return OFS_BOTH;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [N-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [N-1:0] exp, string tag);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic chk_irq(logic exp, string tag);
    chk(tag, {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0; pins = '1; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(OFS_MASK, 32'hFFFF_FFFF, "R1 mask after reset");
    rd(OFS_STS,  32'h0, "R1 status after reset");
    rd(OFS_KIND, 32'h0, "R1 kind after reset");
    rd(OFS_SNS,  32'h0, "R1 sense after reset");
    rd(OFS_BOTH, 32'h0, "R1 both-edges after reset");
    chk_irq(1'b0, "R1 irq after reset");

    // R5 set/clear mask, R9 write-only and unmapped read as zero
    wr(OFS_UNMK, 32'h0000_00FF);
    rd(OFS_MASK, 32'hFFFF_FF00, "R5 unmask write");
    wr(OFS_MSK, 32'h0000_000F);
    rd(OFS_MASK, 32'hFFFF_FF0F, "R5 mask write");
    wr(OFS_UNMK, 32'h0);
    rd(OFS_MASK, 32'hFFFF_FF0F, "R5 zero write leaves mask");
    rd(OFS_UNMK, 32'h0, "R9 unmask word reads zero");
    rd(OFS_MSK,  32'h0, "R9 mask-set word reads zero");
    rd(8'h00,    32'h0, "R9 unmapped reads zero");

    // R9 configuration readback: pins 4..7 edge; 5,7 rising; 7 both edges
    wr(OFS_KIND, 32'h0000_00F0);
    wr(OFS_SNS,  32'h0000_00A0);
    wr(OFS_BOTH, 32'h0000_0080);
    rd(OFS_KIND, 32'h0000_00F0, "R9 kind readback");
    rd(OFS_SNS,  32'h0000_00A0, "R9 sense readback");
    rd(OFS_BOTH, 32'h0000_0080, "R9 both-edges readback");
    rd(OFS_STS,  32'h0, "R2 inactive low-level pins leave status clear");

    // R3 falling on pin 4, none on rising-configured pin 5
    pins = 32'hFFFF_FFCF;
    tick();
    rd(OFS_STS, 32'h0000_0010, "R3 falling edge sense");
    chk_irq(1'b1, "R8 unmasked status raises irq");
    wr(OFS_STS, 32'h0000_0010);
    rd(OFS_STS, 32'h0, "R3 held pin does not retrigger after clear");
    chk_irq(1'b0, "R8 irq drops after clear");

    // R3 rising on pin 5, pin 4 rising ignored
    pins = 32'hFFFF_FFFF;
    tick();
    rd(OFS_STS, 32'h0000_0020, "R3 rising edge sense");
    wr(OFS_STS, 32'h0000_0020);

    // R4 both edges on pin 7
    pins = 32'hFFFF_FF7F;
    tick();
    rd(OFS_STS, 32'h0000_0080, "R4 both-edges falling");
    wr(OFS_STS, 32'h0000_0080);
    pins = 32'hFFFF_FFFF;
    tick();
    rd(OFS_STS, 32'h0000_0080, "R4 both-edges rising");
    wr(OFS_STS, 32'h0000_0080);
    rd(OFS_STS, 32'h0, "R6 clear of edge bit");

    // R6 detection beats clear in the same cycle
    pins = 32'hFFFF_FFEF;
    tick();
    pins = 32'hFFFF_FFFF;
    tick();
    rd(OFS_STS, 32'h0000_0010, "R3 wrong-direction edge keeps bit only");
    pins = 32'hFFFF_FFEF;
    wr(OFS_STS, 32'h0000_0010);
    rd(OFS_STS, 32'h0000_0010, "R6 detection wins over clear");
    wr(OFS_STS, 32'h0000_0010);
    rd(OFS_STS, 32'h0, "R6 clear once edge has passed");

    // R7 masked level-low pin 0 (both-edges bit set, ignored in level mode)
    wr(OFS_BOTH, 32'h0000_0081);
    pins = 32'hFFFF_FFEE;
    tick();
    rd(OFS_STS, 32'h0000_0001, "R4 both-edges ignored in level mode");
    chk_irq(1'b0, "R7 masked pin does not raise irq");
    wr(OFS_UNMK, 32'h0000_0001);
    chk_irq(1'b1, "R7 unmask releases latched status");
    wr(OFS_STS, 32'h0000_0001);
    rd(OFS_STS, 32'h0000_0001, "R2 active level re-sets status");
    pins = 32'hFFFF_FFEF;
    tick();
    rd(OFS_STS, 32'h0000_0001, "R2 status stays after level ends");
    wr(OFS_STS, 32'h0000_0001);
    rd(OFS_STS, 32'h0, "R2 clear after level ends");
    chk_irq(1'b0, "R8 irq low with status clear");

    // R2 active-high level on pin 1
    wr(OFS_SNS, 32'h0000_00A2);
    tick();
    rd(OFS_STS, 32'h0000_0002, "R2 active-high level");
    pins = 32'hFFFF_FFED;
    tick();
    wr(OFS_STS, 32'h0000_0002);
    rd(OFS_STS, 32'h0, "R2 inactive high-level pin clears");

    // R5 mask all
    wr(OFS_MSK, 32'hFFFF_FFFF);
    rd(OFS_MASK, 32'hFFFF_FFFF, "R5 all-ones mask write");
    chk_irq(1'b0, "R8 all masked irq low");

    // Random phase checked against the model
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] exp_rd;
      exp_rd = m_read(addr);
      chk("R8 irq vs model", {{(N-1){1'b0}}, irq},
          {{(N-1){1'b0}}, |(m_sts & ~m_mask)});
      chk(read_tag(addr), rdata, exp_rd);
      pins = pins ^ ($urandom & $urandom & $urandom);
      we   = ($urandom_range(0, 3) == 0);
      addr = pick_addr($urandom_range(0, 7));
      wdata = (addr == OFS_UNMK || addr == OFS_MSK) ? ($urandom & $urandom) : $urandom;
      @(negedge clk);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule